// File: doc/BRIEF.md
# Delay-Slot Next-PC Branch Unit

This block produces the program-counter sequence for a 32-bit RISC pipeline in which every control transfer is followed by one delay-slot instruction. It holds three address registers: the current PC, the next PC and the next-next PC. Every accepted cycle the block is given the current instruction word, a decoded control-flow class, a condition selector, link and likely flags, and two register operands. From these it advances the triple, asks for a return-address write when a link form is seen, and raises an annul flag when a likely branch falls through.

A redirection writes the target into the next-next PC. The instruction after the branch, which is the delay slot, therefore still runs. A likely branch that is not taken advances the triple two places in one cycle, so its delay slot is never issued. Each update is one of four moves, chosen combinationally with a unique case and applied by the state register process. HOLD keeps the triple when the strobe is not accepted. STEP is the plain sequential shift. REDIRECT is a taken branch, a region jump or a register jump. SKIP is a likely branch that falls through. The register process goes from reset to STEP, REDIRECT or SKIP on each accepted cycle, and to HOLD otherwise.

Top module: `dsnpc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the triple loads `pc` = RESET_VEC, `npc` = RESET_VEC+4 and `nnpc` = RESET_VEC+8. With `rst` high, `link_we` and `annul` are 0.
- R2: A cycle is accepted only when `valid` is 1 and `stall` is 0. In any other cycle the triple keeps its value and `link_we` and `annul` are 0, whatever the other inputs are.
- R3: An accepted cycle with class NONE (`cflow`=0), or with a branch that is not taken and not likely, gives `pc`<=`npc`, `npc`<=`nnpc` and `nnpc`<=`nnpc`+4.
- R4: A taken branch (`cflow`=1) gives `pc`<=`npc`, `npc`<=T and `nnpc`<=T+4. T is the current `pc` plus 4 plus the displacement. The displacement is `instr[15:0]` shifted left by 2 and sign-extended from bit 17. Addition wraps modulo 2^32.
- R5: `ccode` selects the branch condition. 0 is always taken. 1 is `rs_val`==`rt_val` and 2 is `rs_val`!=`rt_val`. The next four test `rs_val` as a signed value: 3 is <=0, 4 is >0, 5 is <0 and 6 is >=0. 7 is never taken.
- R6: A region jump (`cflow`=2) redirects as in R4. Its target is bits 31..28 of the current `pc` joined with `instr[25:0]` shifted left by 2.
- R7: A register jump (`cflow`=3) redirects as in R4, with `rs_val` as the target, and it ignores `ccode`.
- R8: An accepted cycle with `link`=1 and a class other than NONE sets `link_we`=1 in that cycle, whether or not the branch is taken. `link_ret` gives the current `nnpc` as the return address.
- R9: A likely branch (`likely`=1, `cflow`=1) that is not taken raises `annul` in that cycle and gives `pc`<=`nnpc`, `npc`<=`nnpc`+4 and `nnpc`<=`nnpc`+8. A likely branch that is taken behaves as in R4, with `annul`=0.
- R10: `likely` has no effect on the two jump classes. They always redirect, and `annul` stays 0.
- R11: `link` has no effect with class NONE, so `link_we` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Current instruction is valid |
| stall | input | 1 | Hold the triple this cycle |
| instr | input | 32 | Current instruction word |
| cflow | input | 2 | Control class: 0 none, 1 branch, 2 region jump, 3 register jump |
| ccode | input | 3 | Branch condition selector (R5) |
| link | input | 1 | Link variant |
| likely | input | 1 | Likely variant (annul the slot when not taken) |
| rs_val | input | 32 | First register operand / jump target |
| rt_val | input | 32 | Second register operand |
| pc | output | 32 | Current PC |
| npc | output | 32 | Next PC |
| nnpc | output | 32 | Next-next PC |
| link_we | output | 1 | Return-address write request |
| link_ret | output | 32 | Return address |
| annul | output | 1 | Delay slot of this likely branch is annulled |

## Verification
The bench runs a chain of branches and compares the triple after each one with an address model of its own. A unit that put the target into `npc` rather than `nnpc` would lose the delay slot, and the very next comparison would show it. Negative displacements and signed zero or minimum operands catch a wrong sign extension or a condition evaluated as unsigned. A likely branch that falls through catches a missing skip or a silent `annul`. A likely flag on a register jump and a link flag on a non-branch check that these flags are ignored. Stalled and invalid cycles that carry a taken jump show whether the triple moves or a link write leaks through.

// File: rtl/dsnpc_pkg.sv
package dsnpc_pkg;

    typedef enum logic [1:0] {
        CF_NONE   = 2'd0,
        CF_BRANCH = 2'd1,
        CF_JUMP   = 2'd2,
        CF_JREG   = 2'd3
    } cflow_e;

    typedef enum logic [2:0] {
        CC_ALWAYS = 3'd0,
        CC_EQ     = 3'd1,
        CC_NE     = 3'd2,
        CC_LEZ    = 3'd3,
        CC_GTZ    = 3'd4,
        CC_LTZ    = 3'd5,
        CC_GEZ    = 3'd6,
        CC_NEVER  = 3'd7
    } ccode_e;

    typedef enum logic [1:0] {
        MV_HOLD     = 2'd0,
        MV_STEP     = 2'd1,
        MV_REDIRECT = 2'd2,
        MV_SKIP     = 2'd3
    } move_e;

endpackage

// File: rtl/dsnpc_cond.sv
module dsnpc_cond
    import dsnpc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [2:0]      ccode,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic            taken
);
    logic rs_zero;
    logic rs_neg;

    assign rs_zero = (rs_val == '0);
    assign rs_neg  = rs_val[XLEN-1];

    always_comb begin
        unique case (ccode_e'(ccode))
            CC_ALWAYS: taken = 1'b1;
            CC_EQ:     taken = (rs_val == rt_val);
            CC_NE:     taken = (rs_val != rt_val);
            CC_LEZ:    taken = rs_neg | rs_zero;
            CC_GTZ:    taken = ~rs_neg & ~rs_zero;
            CC_LTZ:    taken = rs_neg;
            CC_GEZ:    taken = ~rs_neg;
            CC_NEVER:  taken = 1'b0;
            default:   taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/dsnpc_target.sv
module dsnpc_target
    import dsnpc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IW    = 32,
    parameter int IMM_W = 16,
    parameter int IDX_W = 26
) (
    input  logic [1:0]      cflow,
    input  logic [XLEN-1:0] pc,
    input  logic [IW-1:0]   instr,
    input  logic [XLEN-1:0] rs_val,
    output logic [XLEN-1:0] target
);
    localparam int DISP_W   = IMM_W + 2;
    localparam int REGION_W = XLEN - IDX_W - 2;
    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(IW / 8);

    logic [DISP_W-1:0] disp_raw;
    logic [XLEN-1:0]   disp;
    logic [XLEN-1:0]   rel_target;
    logic [XLEN-1:0]   abs_target;

    assign disp_raw   = {instr[IMM_W-1:0], 2'b00};
    assign disp       = {{(XLEN-DISP_W){disp_raw[DISP_W-1]}}, disp_raw};
    assign rel_target = pc + INSN_BYTES + disp;

    generate
        if (REGION_W > 0) begin : g_region
            assign abs_target = {pc[XLEN-1 -: REGION_W], instr[IDX_W-1:0], 2'b00};
        end else begin : g_flat
            assign abs_target = {instr[XLEN-3:0], 2'b00};
        end
    endgenerate

    always_comb begin
        unique case (cflow_e'(cflow))
            CF_BRANCH: target = rel_target;
            CF_JUMP:   target = abs_target;
            CF_JREG:   target = rs_val;
            default:   target = rel_target;
        endcase
    end
endmodule

// File: rtl/dsnpc_seq.sv
module dsnpc_seq
    import dsnpc_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              IW        = 32,
    parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      move,
    input  logic [XLEN-1:0] target,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] npc,
    output logic [XLEN-1:0] nnpc
);
    localparam logic [XLEN-1:0] STEP1 = XLEN'(IW / 8);
    localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * (IW / 8));

    always_ff @(posedge clk) begin
        if (rst) begin
            pc   <= RESET_VEC;
            npc  <= RESET_VEC + STEP1;
            nnpc <= RESET_VEC + STEP2;
        end else begin
            unique case (move_e'(move))
                MV_HOLD: begin
                    pc   <= pc;
                    npc  <= npc;
                    nnpc <= nnpc;
                end
                MV_STEP: begin
                    pc   <= npc;
                    npc  <= nnpc;
                    nnpc <= nnpc + STEP1;
                end
                MV_REDIRECT: begin
                    pc   <= npc;
                    npc  <= target;
                    nnpc <= target + STEP1;
                end
                MV_SKIP: begin
                    pc   <= nnpc;
                    npc  <= nnpc + STEP1;
                    nnpc <= nnpc + STEP2;
                end
                default: begin
                    pc   <= pc;
                    npc  <= npc;
                    nnpc <= nnpc;
                end
            endcase
        end
    end
endmodule

// File: rtl/dsnpc_unit.sv
module dsnpc_unit
    import dsnpc_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              IW        = 32,
    parameter int              IMM_W     = 16,
    parameter int              IDX_W     = 26,
    parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid,
    input  logic            stall,
    input  logic [IW-1:0]   instr,
    input  logic [1:0]      cflow,
    input  logic [2:0]      ccode,
    input  logic            link,
    input  logic            likely,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] npc,
    output logic [XLEN-1:0] nnpc,
    output logic            link_we,
    output logic [XLEN-1:0] link_ret,
    output logic            annul
);
    logic            fire;
    logic            cond_taken;
    logic [XLEN-1:0] target;
    move_e           move;

    assign fire = valid & ~stall & ~rst;

    dsnpc_cond #(.XLEN(XLEN)) cond_i (
        .ccode  (ccode),
        .rs_val (rs_val),
        .rt_val (rt_val),
        .taken  (cond_taken)
    );

    dsnpc_target #(.XLEN(XLEN), .IW(IW), .IMM_W(IMM_W), .IDX_W(IDX_W)) tgt_i (
        .cflow  (cflow),
        .pc     (pc),
        .instr  (instr),
        .rs_val (rs_val),
        .target (target)
    );

    always_comb begin
        if (!fire) begin
            move = MV_HOLD;
        end else begin
            unique case (cflow_e'(cflow))
                CF_NONE:   move = MV_STEP;
                CF_BRANCH: move = cond_taken ? MV_REDIRECT : (likely ? MV_SKIP : MV_STEP);
                CF_JUMP:   move = MV_REDIRECT;
                CF_JREG:   move = MV_REDIRECT;
                default:   move = MV_STEP;
            endcase
        end
    end

    always_comb begin
        annul    = (move == MV_SKIP);
        link_we  = fire & link & (cflow_e'(cflow) != CF_NONE);
        link_ret = nnpc;
    end

    dsnpc_seq #(.XLEN(XLEN), .IW(IW), .RESET_VEC(RESET_VEC)) seq_i (
        .clk    (clk),
        .rst    (rst),
        .move   (move),
        .target (target),
        .pc     (pc),
        .npc    (npc),
        .nnpc   (nnpc)
    );
endmodule

// File: rtl/dsnpc_unit_chk.sv
module dsnpc_unit_chk #(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000
) (
    input logic            clk,
    input logic            rst,
    input logic            valid,
    input logic            stall,
    input logic [1:0]      cflow,
    input logic            link,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] npc,
    input logic [XLEN-1:0] nnpc,
    input logic            link_we,
    input logic            annul
);
    // R1
    reset_vec_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc == RESET_VEC) && (npc == RESET_VEC + 32'd4) && (nnpc == RESET_VEC + 32'd8));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid || stall) |=> $stable(pc) && $stable(npc) && $stable(nnpc));

    // R3
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !stall && !annul) |=> (pc == $past(npc)));

    // R9
    skip_chk: assert property (@(posedge clk) disable iff (rst)
        annul |=> (pc == $past(nnpc)) && (npc == $past(nnpc) + 32'd4));

    // R11
    link_gate_chk: assert property (@(posedge clk) disable iff (rst)
        link_we |-> valid && !stall && link && (cflow != 2'd0));

    // R2
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid || stall) |-> !link_we && !annul);
endmodule

bind dsnpc_unit dsnpc_unit_chk #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .valid   (valid),
    .stall   (stall),
    .cflow   (cflow),
    .link    (link),
    .pc      (pc),
    .npc     (npc),
    .nnpc    (nnpc),
    .link_we (link_we),
    .annul   (annul)
);

// File: tb/dsnpc_unit_test.sv
`timescale 1ns/1ps
module dsnpc_unit_test;
    localparam logic [31:0] RV = 32'hBFC0_0000;

    typedef struct packed {
        logic [1:0]  cls;
        logic [2:0]  cnd;
        logic        lk;
        logic        lik;
        logic [31:0] ins;
        logic [31:0] rs;
        logic [31:0] rt;
        logic        tk;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd0, 1'b0, 1'b0, 32'h0000_0000, 32'h0, 32'h0, 1'b0, 8'd3},          // R3 plain step
        '{2'd1, 3'd0, 1'b0, 1'b0, 32'h0000_0003, 32'h0, 32'h0, 1'b1, 8'd4},          // R4 always, +12
        '{2'd0, 3'd0, 1'b0, 1'b0, 32'h0000_0000, 32'h0, 32'h0, 1'b0, 8'd4},          // R4 delay slot
        '{2'd1, 3'd1, 1'b0, 1'b0, 32'h0000_FFFE, 32'd5, 32'd5, 1'b1, 8'd5},          // R5 EQ, negative disp
        '{2'd0, 3'd0, 1'b0, 1'b0, 32'h0000_0000, 32'h0, 32'h0, 1'b0, 8'd3},
        '{2'd1, 3'd2, 1'b0, 1'b0, 32'h0000_0040, 32'd5, 32'd5, 1'b0, 8'd5},          // R5 NE false
        '{2'd1, 3'd3, 1'b0, 1'b0, 32'h0000_0001, 32'h0, 32'h0, 1'b1, 8'd5},          // R5 LEZ zero
        '{2'd0, 3'd0, 1'b0, 1'b0, 32'h0000_0000, 32'h0, 32'h0, 1'b0, 8'd3},
        '{2'd1, 3'd4, 1'b0, 1'b0, 32'h0000_0020, 32'h0, 32'h0, 1'b0, 8'd5},          // R5 GTZ zero
        '{2'd1, 3'd5, 1'b0, 1'b0, 32'h0000_0010, 32'h8000_0000, 32'h0, 1'b1, 8'd5},  // R5 LTZ min
        '{2'd0, 3'd0, 1'b0, 1'b0, 32'h0000_0000, 32'h0, 32'h0, 1'b0, 8'd3},
        '{2'd1, 3'd6, 1'b0, 1'b1, 32'h0000_0100, 32'hFFFF_FFFF, 32'h0, 1'b0, 8'd9},  // R9 likely falls through
        '{2'd1, 3'd6, 1'b1, 1'b1, 32'h0000_8000, 32'd1, 32'h0, 1'b1, 8'd9},          // R9 likely taken, link
        '{2'd0, 3'd0, 1'b0, 1'b0, 32'h0000_0000, 32'h0, 32'h0, 1'b0, 8'd3},
        '{2'd2, 3'd7, 1'b1, 1'b0, 32'h0812_3456, 32'h0, 32'h0, 1'b1, 8'd6},          // R6 region jump, link
        '{2'd0, 3'd0, 1'b0, 1'b0, 32'h0000_0000, 32'h0, 32'h0, 1'b0, 8'd3},
        '{2'd3, 3'd7, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_1000, 32'h0, 1'b1, 8'd10}, // R10 likely on reg jump
        '{2'd0, 3'd0, 1'b0, 1'b0, 32'h0000_0000, 32'h0, 32'h0, 1'b0, 8'd7},          // R7 slot
        '{2'd0, 3'd0, 1'b1, 1'b0, 32'h0000_0000, 32'h0, 32'h0, 1'b0, 8'd11},         // R11 link with none
        '{2'd1, 3'd7, 1'b0, 1'b0, 32'h0000_0004, 32'h0, 32'h0, 1'b0, 8'd5},          // R5 never
        '{2'd3, 3'd0, 1'b1, 1'b0, 32'h0000_0000, 32'hFFFF_FFF0, 32'h0, 1'b1, 8'd8}   // R8 reg jump link
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid = 1'b0;
    logic        stall = 1'b0;
    logic [31:0] instr = '0;
    logic [1:0]  cflow = '0;
    logic [2:0]  ccode = '0;
    logic        link = 1'b0;
    logic        likely = 1'b0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] pc, npc, nnpc, link_ret;
    logic        link_we, annul;

    int checks = 0;
    int fails = 0;
    logic [31:0] m_pc, m_npc, m_nnpc;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dsnpc_unit #(.RESET_VEC(RV)) uut (
        .clk(clk), .rst(rst), .valid(valid), .stall(stall), .instr(instr),
        .cflow(cflow), .ccode(ccode), .link(link), .likely(likely),
        .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .npc(npc), .nnpc(nnpc),
        .link_we(link_we), .link_ret(link_ret), .annul(annul)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_triple(input string req);
        check(pc == m_pc, req, "pc", pc, m_pc);
        check(npc == m_npc, req, "npc", npc, m_npc);
        check(nnpc == m_nnpc, req, "nnpc", nnpc, m_nnpc);
    endtask

    task automatic run_vec(input vec_t v);
        string       req;
        logic [31:0] tgt;
        logic        exp_annul, exp_link;
        req = $sformatf("R%0d", v.req);
        @(negedge clk);
        valid = 1'b1; stall = 1'b0;
        cflow = v.cls; ccode = v.cnd; link = v.lk; likely = v.lik;
        instr = v.ins; rs_val = v.rs; rt_val = v.rt;
        unique case (v.cls)
            2'd1:    tgt = m_pc + 32'd4 + {{14{v.ins[15]}}, v.ins[15:0], 2'b00};
            2'd2:    tgt = {m_pc[31:28], v.ins[25:0], 2'b00};
            2'd3:    tgt = v.rs;
            default: tgt = '0;
        endcase
        exp_annul = v.lik && (v.cls == 2'd1) && !v.tk;
        exp_link  = v.lk && (v.cls != 2'd0);
        #1;
        check(annul == exp_annul, req, "annul", {31'd0, annul}, {31'd0, exp_annul});
        check(link_we == exp_link, req, "link_we", {31'd0, link_we}, {31'd0, exp_link});
        if (exp_link) check(link_ret == m_nnpc, req, "link_ret", link_ret, m_nnpc);
        if (v.tk) begin
            m_pc = m_npc; m_npc = tgt; m_nnpc = tgt + 32'd4;
        end else if (exp_annul) begin
            m_pc = m_nnpc; m_npc = m_nnpc + 32'd4; m_nnpc = m_nnpc + 32'd8;
        end else begin
            m_pc = m_npc; m_npc = m_nnpc; m_nnpc = m_nnpc + 32'd4;
        end
        @(posedge clk);
        #1;
        check_triple(req);
    endtask

    task automatic reset_model;
        m_pc = RV; m_npc = RV + 32'd4; m_nnpc = RV + 32'd8;
    endtask

    task automatic hold_case(input logic v, input logic s, input logic [1:0] cls,
                             input logic lik, input logic lk);
        @(negedge clk);
        valid = v; stall = s; cflow = cls; ccode = 3'd6; likely = lik; link = lk;
        instr = 32'h0000_0040; rs_val = 32'hFFFF_FFFF; rt_val = '0;
        #1;
        // R2: no link write or annul while not accepted
        check(!link_we, "R2", "link_we hold", {31'd0, link_we}, 32'd0);
        check(!annul, "R2", "annul hold", {31'd0, annul}, 32'd0);
        @(posedge clk);
        #1;
        check_triple("R2");
    endtask

    initial begin
        reset_model();
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check_triple("R1");
        check(!link_we && !annul, "R1", "outputs in reset", {30'd0, link_we, annul}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);
        // R2 stalled taken jump with link, then invalid likely fall-through
        hold_case(1'b1, 1'b1, 2'd2, 1'b0, 1'b1);
        hold_case(1'b0, 1'b0, 2'd1, 1'b1, 1'b1);
        // R1 reset in mid-run
        @(negedge clk);
        rst = 1'b1; valid = 1'b1; cflow = 2'd3;
        @(posedge clk);
        @(posedge clk);
        #1;
        reset_model();
        check_triple("R1");
        @(negedge clk);
        rst = 1'b0; valid = 1'b0; cflow = 2'd0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R2 watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule